// File: doc/BRIEF.md
# Ethernet Receive Address and Error Filter

This block makes the store-or-drop decision for each incoming Ethernet frame. It watches the destination address as it arrives, one byte per strobe. It matches that address against a programmed station address, the broadcast address, or a 64-bit multicast hash mask. While the bytes arrive it also runs a CRC-32 over them, and this CRC supplies the hash index. When the frame ends, a single pulse brings the CRC error flag, the alignment error flag and the frame length. The block weighs these against a six-bit receive configuration and produces a registered decision together with a status byte.

Configuration bits: bit0 keeps errored frames, bit1 keeps short frames, bit2 accepts broadcast, bit3 enables hashed multicast, bit4 accepts every unicast address (promiscuous), and bit5 selects monitor mode. In monitor mode frames are judged but never stored. Byte k of the station address, in arrival order, is `sta_addr[8k+7:8k]`. The first destination byte on the wire sits in the same place.

Top module: `rx_addr_filter`

## Requirements
- R1: With configuration bit0 clear, a frame whose CRC error or alignment error flag is set is not stored. With bit0 set, the error does not by itself stop storage.
- R2: With configuration bit1 clear, a frame whose length is below 64 is not stored. A length of exactly 64 is not short. With bit1 set, length does not by itself stop storage.
- R3: The all-ones destination is accepted only when configuration bit2 is set. It never goes to the hash lookup, so bit3 has no effect on it.
- R4: A destination whose first byte has bit0 set (group address), other than broadcast, is accepted only when configuration bit3 is set and the hash mask bit at index I is 1. I is bits [31:26] of the CRC-32 register after the six address bytes have been shifted in. That CRC is reflected, uses polynomial 0xEDB88320, starts at all ones, takes each byte LSB first and is not complemented at the end. Promiscuous mode does not accept group addresses.
- R5: An individual (unicast) destination is accepted when it equals the station address byte for byte, or when configuration bit4 is set.
- R6: With configuration bit5 set, no frame is stored. A frame that would otherwise pass gets status bit4 (missed), and status bit6 (monitor) is set for every frame.
- R7: Status bit meanings: bit0 = frame stored without error; bit1 = CRC error or alignment error; bit2 = alignment error; bit4 = missed in monitor mode; bit5 = group (multicast or broadcast) destination. Bits 3 and 7 read 0.
- R8: `dec_valid` goes high for exactly the one cycle after the cycle in which `eof` is sampled high. `dec_store` and `dec_status` are updated in that cycle and hold until the next decision.
- R9: After reset, `dec_valid`, `dec_store` and `dec_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sta_addr | input | 48 | Station address, byte k in bits [8k+7:8k] |
| hash_mask | input | 64 | Multicast hash mask, bit I enables index I |
| rx_cfg | input | 6 | Receive configuration bits |
| da_valid | input | 1 | Destination byte strobe |
| da_byte | input | 8 | Destination byte, first byte first |
| eof | input | 1 | End-of-frame pulse |
| eof_crc_err | input | 1 | CRC error flag, valid with eof |
| eof_align_err | input | 1 | Alignment error flag, valid with eof |
| eof_len | input | 16 | Frame length in bytes, valid with eof |
| dec_valid | output | 1 | Decision pulse |
| dec_store | output | 1 | Frame is to be stored |
| dec_status | output | 8 | Receive status byte |

## Verification
The hardest case to reach from the ports is the hashed multicast path. Whether a group address is accepted depends on one mask bit, chosen by a CRC that the ports never show. The bench computes the CRC-32 of a chosen group address with its own bitwise routine. It then programs a mask with only that bit set and expects acceptance, and programs the complement mask and expects rejection. This shows that the index is right and that no neighbouring bit takes part. A fixed table covers the ordering corners: broadcast goes ahead of hashing, promiscuous mode leaves group addresses out, and a length of exactly 64 is the runt limit.

// File: rtl/rx_filt_pkg.sv
`timescale 1ns/1ps
package rx_filt_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;

  // status bit positions
  localparam int ST_OK    = 0;
  localparam int ST_CRC   = 1;
  localparam int ST_ALIGN = 2;
  localparam int ST_MISS  = 4;
  localparam int ST_GROUP = 5;
  localparam int ST_MON   = 6;

  typedef struct packed {
    logic monitor;     // bit5
    logic promisc;     // bit4
    logic take_mcast;  // bit3
    logic take_bcast;  // bit2
    logic keep_short;  // bit1
    logic keep_err;    // bit0
  } rx_cfg_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/da_collector.sv
`timescale 1ns/1ps
module da_collector
  import rx_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [8*ADDR_BYTES-1:0] sta_addr,
  input  logic                    da_valid,
  input  logic [7:0]              da_byte,
  input  logic                    frame_end,
  output logic                    addr_full,
  output logic                    is_group,
  output logic                    all_ones,
  output logic                    phys_hit,
  output logic [IDX_W-1:0]        hash_idx
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q;
  logic             grp_q, ones_q, hit_q;
  logic [7:0]       sta_sel;

  always_comb begin
    sta_sel = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_q == CNT_W'(i)) sta_sel = sta_addr[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      cnt_q  <= '0;
      crc_q  <= CRC_INIT;
      grp_q  <= 1'b0;
      ones_q <= 1'b1;
      hit_q  <= 1'b1;
    end else if (da_valid && cnt_q != LAST) begin
      cnt_q  <= cnt_q + 1'b1;
      crc_q  <= crc_step(crc_q, da_byte);
      ones_q <= ones_q & (da_byte == 8'hFF);
      hit_q  <= hit_q & (da_byte == sta_sel);
      if (cnt_q == '0) grp_q <= da_byte[0];
    end
  end

  assign addr_full = (cnt_q == LAST);
  assign is_group  = grp_q;
  assign all_ones  = ones_q;
  assign phys_hit  = hit_q;
  assign hash_idx  = crc_q[CRC_W-1 -: IDX_W];

  // R5: byte counter never runs past the address length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R5: after a frame end the collector restarts from byte 0
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (cnt_q == '0));
endmodule

// File: rtl/hash_lookup.sv
`timescale 1ns/1ps
module hash_lookup #(
  parameter int HASH_BITS = 64,
  parameter int IDX_W     = $clog2(HASH_BITS)
) (
  input  logic [HASH_BITS-1:0] mask,
  input  logic [IDX_W-1:0]     idx,
  output logic                 hit
);
  assign hit = mask[idx];
endmodule

// File: rtl/accept_decide.sv
`timescale 1ns/1ps
module accept_decide
  import rx_filt_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       rx_cfg,
  input  logic             eof,
  input  logic             crc_err,
  input  logic             align_err,
  input  logic [LEN_W-1:0] len,
  input  logic             addr_full,
  input  logic             is_group,
  input  logic             all_ones,
  input  logic             phys_hit,
  input  logic             hash_hit,
  output logic             dec_valid,
  output logic             dec_store,
  output logic [7:0]       dec_status
);
  rx_cfg_t c;
  logic errd, runt, addr_ok, pass, grp;
  logic [7:0] st;

  assign c = rx_cfg_t'(rx_cfg);

  always_comb begin
    errd = crc_err | align_err;
    runt = (len < LEN_W'(MIN_LEN));
    grp  = addr_full & is_group;
    if (!addr_full)    addr_ok = 1'b0;
    else if (all_ones) addr_ok = c.take_bcast;
    else if (is_group) addr_ok = c.take_mcast & hash_hit;
    else               addr_ok = c.promisc | phys_hit;
    pass = addr_ok & (~errd | c.keep_err) & (~runt | c.keep_short);
    st = '0;
    st[ST_OK]    = pass & ~c.monitor & ~errd;
    st[ST_CRC]   = errd;
    st[ST_ALIGN] = align_err;
    st[ST_MISS]  = pass & c.monitor;
    st[ST_GROUP] = grp;
    st[ST_MON]   = c.monitor;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_store  <= 1'b0;
      dec_status <= '0;
    end else begin
      dec_valid <= eof;
      if (eof) begin
        dec_store  <= pass & ~c.monitor;
        dec_status <= st;
      end
    end
  end

  p_err_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (eof && (crc_err || align_err) && !rx_cfg[0]) |=> !dec_store);
  p_runt_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (eof && (len < LEN_W'(MIN_LEN)) && !rx_cfg[1]) |=> !dec_store);
  p_monitor_r6: assert property (@(posedge clk) disable iff (rst)
    (eof && rx_cfg[5]) |=> (!dec_store && dec_status[ST_MON]));
  p_align_crc_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_status[ST_ALIGN]) |-> dec_status[ST_CRC]);
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    eof |=> dec_valid);
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !eof |=> !dec_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !eof |=> ($stable(dec_store) && $stable(dec_status)));
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [8*ADDR_BYTES-1:0] sta_addr,
  input  logic [HASH_BITS-1:0]    hash_mask,
  input  logic [5:0]              rx_cfg,
  input  logic                    da_valid,
  input  logic [7:0]              da_byte,
  input  logic                    eof,
  input  logic                    eof_crc_err,
  input  logic                    eof_align_err,
  input  logic [LEN_W-1:0]        eof_len,
  output logic                    dec_valid,
  output logic                    dec_store,
  output logic [7:0]              dec_status
);
  localparam int IDX_W = $clog2(HASH_BITS);

  logic             addr_full, is_group, all_ones, phys_hit, hash_hit;
  logic [IDX_W-1:0] hash_idx;

  da_collector #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_coll (
    .clk(clk), .rst(rst), .sta_addr(sta_addr),
    .da_valid(da_valid), .da_byte(da_byte), .frame_end(eof),
    .addr_full(addr_full), .is_group(is_group), .all_ones(all_ones),
    .phys_hit(phys_hit), .hash_idx(hash_idx)
  );

  hash_lookup #(.HASH_BITS(HASH_BITS), .IDX_W(IDX_W)) u_hash (
    .mask(hash_mask), .idx(hash_idx), .hit(hash_hit)
  );

  accept_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dec (
    .clk(clk), .rst(rst), .rx_cfg(rx_cfg), .eof(eof),
    .crc_err(eof_crc_err), .align_err(eof_align_err), .len(eof_len),
    .addr_full(addr_full), .is_group(is_group), .all_ones(all_ones),
    .phys_hit(phys_hit), .hash_hit(hash_hit),
    .dec_valid(dec_valid), .dec_store(dec_store), .dec_status(dec_status)
  );
endmodule

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] sta_addr = 48'h665544332202;
  logic [63:0] hash_mask = '1;
  logic [5:0]  rx_cfg = '0;
  logic        da_valid = 1'b0;
  logic [7:0]  da_byte = '0;
  logic        eof = 1'b0, eof_crc_err = 1'b0, eof_align_err = 1'b0;
  logic [15:0] eof_len = '0;
  logic        dec_valid, dec_store;
  logic [7:0]  dec_status;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst(rst), .sta_addr(sta_addr), .hash_mask(hash_mask),
    .rx_cfg(rx_cfg), .da_valid(da_valid), .da_byte(da_byte), .eof(eof),
    .eof_crc_err(eof_crc_err), .eof_align_err(eof_align_err),
    .eof_len(eof_len), .dec_valid(dec_valid), .dec_store(dec_store),
    .dec_status(dec_status)
  );

  typedef struct packed {
    logic [47:0] da;
    logic [5:0]  cfg;
    logic        ce;
    logic        ae;
    logic [15:0] len;
    logic        st;
    logic [7:0]  stat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{48'h665544332202, 6'h00, 1'b0, 1'b0, 16'd100, 1'b1, 8'h01}, // R5 own address
    '{48'h665544332204, 6'h00, 1'b0, 1'b0, 16'd100, 1'b0, 8'h00}, // R5 foreign unicast
    '{48'h665544332204, 6'h10, 1'b0, 1'b0, 16'd100, 1'b1, 8'h01}, // R5 promiscuous
    '{48'hFFFFFFFFFFFF, 6'h00, 1'b0, 1'b0, 16'd100, 1'b0, 8'h20}, // R3 bcast off
    '{48'hFFFFFFFFFFFF, 6'h04, 1'b0, 1'b0, 16'd100, 1'b1, 8'h21}, // R3 bcast on
    '{48'h665544332202, 6'h00, 1'b1, 1'b0, 16'd100, 1'b0, 8'h02}, // R1 crc drop
    '{48'h665544332202, 6'h01, 1'b1, 1'b0, 16'd100, 1'b1, 8'h02}, // R1 crc kept, R7 no ok bit
    '{48'h665544332202, 6'h00, 1'b0, 1'b1, 16'd100, 1'b0, 8'h06}, // R1 align drop, R7
    '{48'h665544332202, 6'h00, 1'b0, 1'b0, 16'd63,  1'b0, 8'h00}, // R2 runt drop
    '{48'h665544332202, 6'h02, 1'b0, 1'b0, 16'd63,  1'b1, 8'h01}, // R2 runt kept
    '{48'h665544332202, 6'h00, 1'b0, 1'b0, 16'd64,  1'b1, 8'h01}, // R2 boundary 64
    '{48'h665544332202, 6'h20, 1'b0, 1'b0, 16'd100, 1'b0, 8'h50}, // R6 missed
    '{48'h665544332204, 6'h20, 1'b0, 1'b0, 16'd100, 1'b0, 8'h40}, // R6 rejected in monitor
    '{48'h0000005E0001, 6'h08, 1'b0, 1'b0, 16'd100, 1'b1, 8'h21}, // R4 full mask
    '{48'h0000005E0001, 6'h00, 1'b0, 1'b0, 16'd100, 1'b0, 8'h20}, // R4 mcast off
    '{48'hFFFFFFFFFFFF, 6'h08, 1'b0, 1'b0, 16'd100, 1'b0, 8'h20}, // R3 not hashed
    '{48'hFFFFFFFFFFFF, 6'h24, 1'b0, 1'b0, 16'd100, 1'b0, 8'h70}  // R6 bcast missed
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ da[8*k+i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c[31:26];
  endfunction

  // drives a frame; returns at the negedge where the decision is visible
  task automatic send(input logic [47:0] da, input logic ce, input logic ae,
                      input logic [15:0] len);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      da_valid = 1'b1;
      da_byte  = da[8*k +: 8];
    end
    @(negedge clk);
    da_valid = 1'b0;
    eof = 1'b1; eof_crc_err = ce; eof_align_err = ae; eof_len = len;
    @(negedge clk);
    eof = 1'b0; eof_crc_err = 1'b0; eof_align_err = 1'b0;
  endtask

  initial begin
    logic [5:0] idx;
    repeat (3) @(negedge clk);
    chk("R9 valid after reset", {7'b0, dec_valid}, 8'h00);
    chk("R9 store after reset", {7'b0, dec_store}, 8'h00);
    chk("R9 status after reset", dec_status, 8'h00);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      rx_cfg = VECS[v].cfg;
      send(VECS[v].da, VECS[v].ce, VECS[v].ae, VECS[v].len);
      chk($sformatf("R8 table vec %0d valid", v), {7'b0, dec_valid}, 8'h01);
      chk($sformatf("table vec %0d store", v), {7'b0, dec_store}, {7'b0, VECS[v].st});
      chk($sformatf("R7 table vec %0d status", v), dec_status, VECS[v].stat);
      @(negedge clk);
      chk($sformatf("R8 table vec %0d pulse end", v), {7'b0, dec_valid}, 8'h00);
      chk($sformatf("R8 table vec %0d hold", v), dec_status, VECS[v].stat);
    end

    // R4: single hash bit selected by the CRC index
    idx = ref_idx(48'h0000005E0001);
    rx_cfg = 6'h08;
    hash_mask = 64'd1 << idx;
    send(48'h0000005E0001, 1'b0, 1'b0, 16'd100);
    chk("R4 single bit hit store", {7'b0, dec_store}, 8'h01);
    chk("R4 single bit hit status", dec_status, 8'h21);
    hash_mask = ~(64'd1 << idx);
    send(48'h0000005E0001, 1'b0, 1'b0, 16'd100);
    chk("R4 complement mask miss", {7'b0, dec_store}, 8'h00);
    chk("R4 complement mask status", dec_status, 8'h20);
    // R4: promiscuous does not admit group addresses
    hash_mask = '1;
    rx_cfg = 6'h10;
    send(48'h0000005E0001, 1'b0, 1'b0, 16'd100);
    chk("R4 promisc ignores group", {7'b0, dec_store}, 8'h00);

    // R9: reset mid-stream clears outputs
    rx_cfg = 6'h00;
    send(48'h665544332202, 1'b0, 1'b0, 16'd100);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 store cleared by reset", {7'b0, dec_store}, 8'h00);
    chk("R9 status cleared by reset", dec_status, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule